// File: doc/BRIEF.md
# Serial-Clock Hold Synchronization and Power-Down Controller

This block sits beside the output shift logic of a delta-sigma converter and watches the serial clock while no read is in progress. The serial clock normally rests low. A host that keeps it high on purpose makes a request, and the block reads that request from the number of whole conversion periods the clock stays high. A short hold stops the modulator and the decimation filter so that several converters can restart together. A much longer hold also turns off the converter. Both states end on the next falling edge of the serial clock.

The block takes a one-cycle tick at each conversion-period boundary and a serial clock input that has already been brought into the system clock domain. It drives a reset for the modulator and filter, a power-down request, and an override for the shared data-ready/data-out pin. The override is a pair of signals: an enable, and the level the pin must show while the enable is high. A settle counter restarts whenever the converter leaves reset. The block flags results as valid only once the filter has seen enough periods to settle fully.

Top module: `sclk_hold_ctrl`

## Requirements
- R1: After reset, mod_reset, power_down, pin_force and settled are 0, and pin_level is 1.
- R2: The hold count rises by one at each period tick that samples sclk_sync high. It returns to zero at a tick that samples sclk_sync low, and at any falling edge of sclk_sync. So only a hold that is unbroken across consecutive ticks counts.
- R3: At the tick where the count reaches SYNC_PERIODS (default 4), mod_reset and pin_force go to 1 in the next cycle.
- R4: On entry to the synchronization state, pin_level is 0 for exactly LOW_PULSE (default 3) clock cycles. It is then 1 until release.
- R5: At the tick where the count reaches PDN_PERIODS (default 20), power_down goes to 1 in the next cycle. The count then saturates, and power_down stays 1 while the hold lasts.
- R6: A hold of at least SYNC_PERIODS but fewer than PDN_PERIODS ticks gives mod_reset without power_down.
- R7: A falling edge of sclk_sync releases either state. The cycle after the low level is first sampled, mod_reset, power_down and pin_force are all 0.
- R8: settled is 1 only while not in reset, and only after SETTLE_PERIODS (default 5) period ticks since the last release or block reset. Entering the synchronization state clears it.
- R9: While power_down is 1, mod_reset and pin_force are also 1.
- R10: A hold of fewer than SYNC_PERIODS ticks changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_tick | input | 1 | One-cycle pulse at each conversion-period boundary |
| sclk_sync | input | 1 | Serial clock, already synchronized to clk |
| mod_reset | output | 1 | Holds the modulator and filter in reset |
| power_down | output | 1 | Power-down request |
| pin_force | output | 1 | Data-ready pin override enable |
| pin_level | output | 1 | Level driven on the data-ready pin while pin_force is 1 |
| settled | output | 1 | Filter has settled since the last restart |

## Verification
A hold count that drifts by one moves the assertion of mod_reset or power_down by a whole conversion period. The first tick after the intended threshold therefore shows the error. If the falling edge fails to clear the count, a broken hold asserts reset early. A wrong pulse counter shows on pin_level within LOW_PULSE+1 cycles of entry. A settle counter that is not restarted raises settled several ticks early after release. Comparing every output against a reference model each cycle catches each of these on the first cycle it diverges.

// File: rtl/sclk_hold_ctrl.sv
module sclk_hold_ctrl #(
  parameter int SYNC_PERIODS   = 4,
  parameter int PDN_PERIODS    = 20,
  parameter int LOW_PULSE      = 3,
  parameter int SETTLE_PERIODS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic period_tick,
  input  logic sclk_sync,
  output logic mod_reset,
  output logic power_down,
  output logic pin_force,
  output logic pin_level,
  output logic settled
);
  localparam int CW = $clog2(PDN_PERIODS + 1);
  localparam int PW = $clog2(LOW_PULSE + 1);
  localparam int SW = $clog2(SETTLE_PERIODS + 1);
  localparam logic [CW-1:0] SYNC_AT = CW'(SYNC_PERIODS);
  localparam logic [CW-1:0] OFF_AT  = CW'(PDN_PERIODS);
  localparam logic [PW-1:0] PULSE_LEN = PW'(LOW_PULSE);
  localparam logic [SW-1:0] SETTLE_AT = SW'(SETTLE_PERIODS);

  typedef enum logic [1:0] {ST_RUN, ST_HOLD, ST_OFF} st_t;

  st_t           st;
  logic [CW-1:0] hold_cnt;
  logic [PW-1:0] low_cnt;
  logic [SW-1:0] settle_cnt;
  logic          sclk_q;

  wire fall      = sclk_q & ~sclk_sync;
  wire high_tick = period_tick & sclk_sync;
  wire [CW-1:0] cnt_inc = (hold_cnt == OFF_AT) ? hold_cnt : hold_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_RUN;
      hold_cnt   <= '0;
      low_cnt    <= '0;
      settle_cnt <= '0;
      sclk_q     <= 1'b0;
    end else begin
      sclk_q <= sclk_sync;
      case (st)
        ST_RUN: begin
          if (fall)             hold_cnt <= '0;
          else if (period_tick) hold_cnt <= sclk_sync ? cnt_inc : '0;
          if (!fall && high_tick && cnt_inc == SYNC_AT) begin
            st         <= ST_HOLD;
            low_cnt    <= PULSE_LEN;
            settle_cnt <= '0;
          end else if (period_tick && settle_cnt != SETTLE_AT) begin
            settle_cnt <= settle_cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (fall) begin
            st         <= ST_RUN;
            hold_cnt   <= '0;
            low_cnt    <= '0;
            settle_cnt <= '0;
          end else begin
            if (low_cnt != '0) low_cnt <= low_cnt - 1'b1;
            if (high_tick) begin
              hold_cnt <= cnt_inc;
              if (cnt_inc == OFF_AT) st <= ST_OFF;
            end
          end
        end
        default: begin
          if (fall) begin
            st         <= ST_RUN;
            hold_cnt   <= '0;
            low_cnt    <= '0;
            settle_cnt <= '0;
          end
        end
      endcase
    end
  end

  assign mod_reset  = (st != ST_RUN);
  assign power_down = (st == ST_OFF);
  assign pin_force  = (st != ST_RUN);
  assign pin_level  = (low_cnt == '0);
  assign settled    = (st == ST_RUN) && (settle_cnt == SETTLE_AT);
endmodule

// File: rtl/sclk_hold_ctrl_chk.sv
module sclk_hold_ctrl_chk #(
  parameter int LOW_PULSE = 3
) (
  input logic clk,
  input logic rst_n,
  input logic period_tick,
  input logic sclk_sync,
  input logic mod_reset,
  input logic power_down,
  input logic pin_force,
  input logic pin_level,
  input logic settled
);
  int low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      low_run <= 0;
    else if (pin_force && !pin_level) low_run <= low_run + 1;
    else                             low_run <= 0;
  end

  assert_entry_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_reset) |-> $past(period_tick) && $past(sclk_sync));

  assert_entry_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_force) |-> !pin_level);

  assert_pulse_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= LOW_PULSE);

  assert_off_after_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_down) |-> $past(mod_reset));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_sync) |=> !mod_reset && !power_down && !pin_force);

  assert_no_settle_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mod_reset |-> !settled);

  assert_off_implies_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> mod_reset && pin_force);
endmodule

bind sclk_hold_ctrl sclk_hold_ctrl_chk #(.LOW_PULSE(LOW_PULSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .period_tick(period_tick), .sclk_sync(sclk_sync),
  .mod_reset(mod_reset), .power_down(power_down), .pin_force(pin_force),
  .pin_level(pin_level), .settled(settled)
);

// File: tb/sclk_hold_ctrl_test.sv
module sclk_hold_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic period_tick = 1'b0;
  logic sclk_sync = 1'b0;
  logic mod_reset, power_down, pin_force, pin_level, settled;

  int errors = 0;
  int checks = 0;
  int ticks_seen = 0;
  int gap_cnt = 0;
  bit compare_on = 1'b0;

  int m_state = 0;
  int m_cnt = 0;
  int m_low = 0;
  int m_settle = 0;
  bit m_prev = 1'b0;

  sclk_hold_ctrl uut (
    .clk(clk), .rst_n(rst_n), .period_tick(period_tick), .sclk_sync(sclk_sync),
    .mod_reset(mod_reset), .power_down(power_down), .pin_force(pin_force),
    .pin_level(pin_level), .settled(settled)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    gap_cnt <= (gap_cnt == GAP-1) ? 0 : gap_cnt + 1;
    period_tick <= (gap_cnt == GAP-2);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_low = 0; m_settle = 0; m_prev = 1'b0;
    end else begin
      if (period_tick) ticks_seen++;
      if (m_prev && !sclk_sync && m_state != 0) begin
        m_state = 0; m_cnt = 0; m_low = 0; m_settle = 0;
      end else if (m_state == 0) begin
        if (m_prev && !sclk_sync) m_cnt = 0;
        else if (period_tick) m_cnt = sclk_sync ? (m_cnt < 20 ? m_cnt + 1 : 20) : 0;
        if (m_cnt == 4 && period_tick && sclk_sync) begin
          m_state = 1; m_low = 3; m_settle = 0;
        end else if (period_tick && m_settle < 5) m_settle++;
      end else if (m_state == 1) begin
        if (m_low > 0) m_low--;
        if (period_tick && sclk_sync) begin
          m_cnt++;
          if (m_cnt == 20) m_state = 2;
        end
      end
      m_prev = sclk_sync;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on) begin
      chk("R3 mod_reset model", mod_reset, m_state != 0);
      chk("R5 power_down model", power_down, m_state == 2);
      chk("R3 pin_force model", pin_force, m_state != 0);
      chk("R4 pin_level model", pin_level, m_low == 0);
      chk("R8 settled model", settled, m_state == 0 && m_settle == 5);
    end
  end

  task automatic wait_ticks(int n);
    int target = ticks_seen + n;
    while (ticks_seen < target) @(negedge clk);
  endtask

  task automatic set_sclk(logic v);
    @(negedge clk);
    sclk_sync = v;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mod_reset", mod_reset, 1'b0);
    chk("R1 power_down", power_down, 1'b0);
    chk("R1 pin_force", pin_force, 1'b0);
    chk("R1 pin_level", pin_level, 1'b1);
    chk("R1 settled", settled, 1'b0);
    compare_on = 1'b1;

    wait_ticks(6);
    chk("R8 settled after power-up", settled, 1'b1);

    set_sclk(1'b1);
    wait_ticks(3);
    chk("R10 short hold mod_reset", mod_reset, 1'b0);
    chk("R10 short hold pin_force", pin_force, 1'b0);
    chk("R10 short hold settled", settled, 1'b1);
    set_sclk(1'b0);
    wait_ticks(2);

    set_sclk(1'b1);
    wait_ticks(3);
    set_sclk(1'b0);
    set_sclk(1'b1);
    wait_ticks(3);
    chk("R2 broken hold restarts count", mod_reset, 1'b0);
    wait_ticks(1);
    chk("R3 sync entry mod_reset", mod_reset, 1'b1);
    chk("R4 pulse starts low", pin_level, 1'b0);
    chk("R8 cleared on entry", settled, 1'b0);
    repeat (2) @(negedge clk);
    chk("R4 third low cycle", pin_level, 1'b0);
    @(negedge clk);
    chk("R4 level high after pulse", pin_level, 1'b1);
    wait_ticks(10);
    chk("R6 no power_down in sync window", power_down, 1'b0);
    chk("R6 still in reset", mod_reset, 1'b1);
    set_sclk(1'b0);
    @(negedge clk);
    chk("R7 release mod_reset", mod_reset, 1'b0);
    chk("R7 release pin_force", pin_force, 1'b0);
    chk("R8 not settled right after release", settled, 1'b0);
    wait_ticks(4);
    chk("R8 not settled after 4 ticks", settled, 1'b0);
    wait_ticks(1);
    chk("R8 settled after 5 ticks", settled, 1'b1);

    set_sclk(1'b1);
    wait_ticks(19);
    chk("R5 no power_down at 19", power_down, 1'b0);
    wait_ticks(1);
    chk("R5 power_down at 20", power_down, 1'b1);
    chk("R9 reset with power_down", mod_reset, 1'b1);
    chk("R9 force with power_down", pin_force, 1'b1);
    wait_ticks(3);
    chk("R5 power_down held", power_down, 1'b1);
    set_sclk(1'b0);
    @(negedge clk);
    chk("R7 release power_down", power_down, 1'b0);
    chk("R7 release mod_reset from off", mod_reset, 1'b0);
    wait_ticks(6);
    chk("R8 settled after off", settled, 1'b1);

    compare_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule